// File: doc/BRIEF.md
# Key Event Queue with Selectable Full Policy

This block is a small first-in, first-out store for keypad and general-purpose-input events. Each stored byte carries a press flag in its top bit and a 7-bit key code below it. Event sources push bytes at the tail. The host side sees the oldest byte at all times, and a read strobe removes it. The block reports how many events are held, keeps a sticky overflow flag, and keeps a pending flag that the host may clear only once the queue has been emptied.

When an event arrives while every slot is occupied, a mode input selects the policy. The drop policy discards the new event and leaves the stored events untouched. The evict policy discards the oldest event and appends the new one. Either policy raises the overflow flag. If a read and a push land in the same cycle on a full queue, the read frees a slot first, so the push is accepted and no overflow is recorded.

Top module: `key_event_queue`

## Requirements
- R1: `count_o` reports the number of stored events, from 0 up to DEPTH (10 by default, a 4-bit field), and never exceeds DEPTH.
- R2: Stored bytes pass through unaltered. Bit 7 is 1 for a press and 0 for a release, and bits 6:0 hold the key code. Codes 1 to 80 are matrix keys, 97 to 104 are rows used as inputs, and 105 to 114 are columns used as inputs.
- R3: `head_o` shows the oldest stored event. A cycle with `pop_i` high on a non-empty queue removes it, moves the rest one place toward the head, and lowers the count by one.
- R4: With the queue empty, `head_o` reads 0x00, and `pop_i` leaves the count at zero.
- R5: A push without a pop while DEPTH events are stored sets `ovf_o`.
- R6: On a full queue with `full_mode_i` at 0, a push is discarded and the contents stay unchanged. With `full_mode_i` at 1, the oldest entry is dropped and the new event is appended at the tail. In both cases the count stays at DEPTH.
- R7: `pend_o` is set by every accepted push and stays set while any event is queued. `pend_clr_i` clears it only in a cycle where the count is zero and no push is accepted.
- R8: A push and a pop in the same cycle on a full queue pop first and then accept the push. The count stays at DEPTH and `ovf_o` is not set.
- R9: `ovf_o` stays set until `ovf_clr_i` is asserted. If a new overflow occurs in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Append `push_data_i` as a new event |
| push_data_i | input | 8 | Event byte: press flag in bit 7, key code in bits 6:0 |
| pop_i | input | 1 | Remove the head event (head read) |
| full_mode_i | input | 1 | Full policy: 0 drops the new event, 1 evicts the oldest |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| pend_clr_i | input | 1 | Host request to clear the pending flag |
| head_o | output | 8 | Oldest event, or 0x00 when empty |
| count_o | output | 4 | Number of stored events |
| ovf_o | output | 1 | Sticky overflow flag |
| pend_o | output | 1 | Key-event pending flag |

## Verification
The bench builds the block with its default parameters: ten 8-bit entries and a 4-bit count. This makes the full boundary reachable in ten pushes, so the drop policy, the evict policy and the simultaneous push-and-pop case on a full queue can each be driven directly. The default code width lets the bench push the matrix and input code ranges exactly as the host would read them back.

// File: rtl/kevq_pkg.sv
package kevq_pkg;

   // Policy applied when an event arrives at a full queue
   typedef enum logic {
      FULL_DROP  = 1'b0,
      FULL_EVICT = 1'b1
   } full_policy_e;

   // Per-cycle decisions made by the controller
   typedef struct packed {
      logic do_pop;   // head removed this cycle
      logic shift;    // entries move one slot toward the head
      logic wr_en;    // an event byte is written
      logic evict;    // full queue, oldest entry dropped for the new one
      logic ovf_hit;  // push met a full queue with no pop to free a slot
   } q_ctl_t;

endpackage

// File: rtl/kevq_ctrl.sv
module kevq_ctrl
   import kevq_pkg::*;
#(
   parameter int DEPTH = 10,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             mode_i,
   output logic [CNT_W-1:0] count_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output q_ctl_t           ctl_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [IDX_W-1:0] TAIL_IDX = IDX_W'(DEPTH - 1);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] after_pop;
   logic             is_full;
   q_ctl_t           ctl;

   always_comb begin
      is_full      = (count_q == FULL_CNT);
      ctl.do_pop   = pop_i && (count_q != '0);
      ctl.ovf_hit  = push_i && is_full && !ctl.do_pop;
      ctl.evict    = ctl.ovf_hit && (full_policy_e'(mode_i) == FULL_EVICT);
      ctl.wr_en    = push_i && (!ctl.ovf_hit || ctl.evict);
      ctl.shift    = ctl.do_pop || ctl.evict;
      after_pop    = count_q - CNT_W'(ctl.do_pop);
      wr_idx_o     = ctl.evict ? TAIL_IDX : IDX_W'(after_pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (ctl.wr_en && !ctl.evict) begin
         count_q <= after_pop + CNT_W'(1);
      end else begin
         count_q <= after_pop;
      end
   end

   assign count_o = count_q;
   assign ctl_o   = ctl;

endmodule

// File: rtl/kevq_store.sv
module kevq_store #(
   parameter int DEPTH   = 10,
   parameter int ENTRY_W = 8,
   parameter int IDX_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [ENTRY_W-1:0] wr_data_i,
   output logic [ENTRY_W-1:0] head_o
);

   logic [ENTRY_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ENTRY_W-1:0] from_behind;

      // The last slot refills with zero when the queue moves forward
      if (i == DEPTH - 1) begin : g_tail
         assign from_behind = '0;
      end else begin : g_body
         assign from_behind = slot_q[i+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
            slot_q[i] <= wr_data_i;
         end else if (shift_i) begin
            slot_q[i] <= from_behind;
         end
      end
   end

   assign head_o = slot_q[0];

endmodule

// File: rtl/kevq_flags.sv
module kevq_flags #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_hit_i,
   input  logic             ovf_clr_i,
   input  logic             accepted_i,
   input  logic             pend_clr_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             ovf_o,
   output logic             pend_o
);

   logic ovf_q;
   logic pend_q;

   // A new overflow wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (ovf_hit_i) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr_i) begin
         ovf_q <= 1'b0;
      end
   end

   // Pending may only drop once nothing is queued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (accepted_i) begin
         pend_q <= 1'b1;
      end else if (pend_clr_i && (count_i == '0)) begin
         pend_q <= 1'b0;
      end
   end

   assign ovf_o  = ovf_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
   import kevq_pkg::*;
#(
   parameter int DEPTH  = 10,
   parameter int CODE_W = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push_i,
   input  logic [CODE_W:0]             push_data_i,
   input  logic                        pop_i,
   input  logic                        full_mode_i,
   input  logic                        ovf_clr_i,
   input  logic                        pend_clr_i,
   output logic [CODE_W:0]             head_o,
   output logic [$clog2(DEPTH+1)-1:0]  count_o,
   output logic                        ovf_o,
   output logic                        pend_o
);

   localparam int ENTRY_W = CODE_W + 1;
   localparam int CNT_W   = $clog2(DEPTH + 1);
   localparam int IDX_W   = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("key_event_queue: DEPTH must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("key_event_queue: CODE_W must be at least 1");
   end

   q_ctl_t             ctl;
   logic [IDX_W-1:0]   wr_idx;
   logic [ENTRY_W-1:0] head_raw;
   logic [CNT_W-1:0]   count;

   kevq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push_i),
      .pop_i    (pop_i),
      .mode_i   (full_mode_i),
      .count_o  (count),
      .wr_idx_o (wr_idx),
      .ctl_o    (ctl)
   );

   kevq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_i   (ctl.shift),
      .wr_en_i   (ctl.wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (push_data_i),
      .head_o    (head_raw)
   );

   kevq_flags #(.CNT_W(CNT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .ovf_hit_i  (ctl.ovf_hit),
      .ovf_clr_i  (ovf_clr_i),
      .accepted_i (ctl.wr_en),
      .pend_clr_i (pend_clr_i),
      .count_i    (count),
      .ovf_o      (ovf_o),
      .pend_o     (pend_o)
   );

   assign head_o  = (count == '0) ? '0 : head_raw;
   assign count_o = count;

endmodule

// File: rtl/kevq_chk.sv
module kevq_chk #(
   parameter int DEPTH   = 10,
   parameter int ENTRY_W = 8,
   parameter int CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               push_i,
   input logic               pop_i,
   input logic               full_mode_i,
   input logic               ovf_clr_i,
   input logic [ENTRY_W-1:0] head_o,
   input logic [CNT_W-1:0]   count_o,
   input logic               ovf_o,
   input logic               pend_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= FULL_CNT);

   // R3
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

   // R4
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0) |-> (head_o == '0));

   // R5
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && count_o == FULL_CNT) |=> ovf_o);

   // R6
   drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !full_mode_i && count_o == FULL_CNT)
         |=> (count_o == FULL_CNT && $stable(head_o)));

   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != '0) |-> pend_o);

   // R8
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !ovf_clr_i && count_o == FULL_CNT)
         |=> (count_o == FULL_CNT && ovf_o == $past(ovf_o)));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

endmodule

bind key_event_queue kevq_chk #(
   .DEPTH   (DEPTH),
   .ENTRY_W (CODE_W + 1),
   .CNT_W   ($clog2(DEPTH + 1))
) u_kevq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .full_mode_i (full_mode_i),
   .ovf_clr_i   (ovf_clr_i),
   .head_o      (head_o),
   .count_o     (count_o),
   .ovf_o       (ovf_o),
   .pend_o      (pend_o)
);

// File: tb/tb_key_event_queue.sv
module tb_key_event_queue;

   localparam int DEPTH = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic [7:0] push_data_i = '0;
   logic       pop_i = 1'b0;
   logic       full_mode_i = 1'b0;
   logic       ovf_clr_i = 1'b0;
   logic       pend_clr_i = 1'b0;
   logic [7:0] head_o;
   logic [3:0] count_o;
   logic       ovf_o;
   logic       pend_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] mq[$];
   logic [7:0] fill_set [DEPTH] = '{8'h81, 8'hA0, 8'h01, 8'h20, 8'h97,
                                    8'h17, 8'hAD, 8'hA9, 8'h29, 8'h2D};

   always #5 clk = ~clk;

   key_event_queue dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
      .pop_i(pop_i), .full_mode_i(full_mode_i), .ovf_clr_i(ovf_clr_i),
      .pend_clr_i(pend_clr_i), .head_o(head_o), .count_o(count_o),
      .ovf_o(ovf_o), .pend_o(pend_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Each operation starts just after a falling edge and ends at the next one
   task automatic op_push(input logic [7:0] d);
      push_i = 1'b1; push_data_i = d;
      if (mq.size() == DEPTH) begin
         if (full_mode_i) begin
            void'(mq.pop_front());
            mq.push_back(d);
         end
      end else begin
         mq.push_back(d);
      end
      @(negedge clk);
      push_i = 1'b0;
   endtask

   task automatic op_pop(input string req);
      logic [7:0] exp;
      exp = (mq.size() != 0) ? mq.pop_front() : 8'h00;
      chk(req, head_o, exp);
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
      chk(req, count_o, mq.size());
   endtask

   task automatic pulse_clr(input bit ovf, input bit pend);
      ovf_clr_i = ovf; pend_clr_i = pend;
      @(negedge clk);
      ovf_clr_i = 1'b0; pend_clr_i = 1'b0;
   endtask

   task automatic fill_up();
      foreach (fill_set[i]) op_push(fill_set[i]);
   endtask

   task automatic drain(input string req);
      while (mq.size() != 0) op_pop(req);
   endtask

   task automatic t_reset();
      chk("R1 reset count", count_o, 0);
      chk("R4 reset head", head_o, 0);
      chk("R5 reset ovf", ovf_o, 0);
      chk("R7 reset pend", pend_o, 0);
   endtask

   task automatic t_order();
      fill_up();
      chk("R1 full count", count_o, DEPTH);
      chk("R7 pend after push", pend_o, 1);
      pulse_clr(1'b0, 1'b1);
      chk("R7 clear refused", pend_o, 1);
      drain("R3 order");
      op_pop("R4 empty read");
      chk("R4 empty head", head_o, 0);
      pulse_clr(1'b0, 1'b1);
      chk("R7 clear when empty", pend_o, 0);
   endtask

   task automatic t_codes();
      op_push(8'hE1);   // press, code 97 (row 0 as input)
      op_push(8'h72);   // release, code 114 (column 9 as input)
      op_push(8'hD0);   // press, code 80 (last matrix key)
      chk("R2 press flag", head_o[7], 1);
      chk("R2 code field", head_o[6:0], 97);
      op_pop("R2 head");
      chk("R2 release flag", head_o[7], 0);
      chk("R2 column code", head_o[6:0], 114);
      drain("R2 drain");
      pulse_clr(1'b0, 1'b1);
   endtask

   task automatic t_drop();
      full_mode_i = 1'b0;
      fill_up();
      op_push(8'h82);
      chk("R5 ovf on drop", ovf_o, 1);
      chk("R6 drop count", count_o, DEPTH);
      repeat (3) @(negedge clk);
      chk("R9 ovf sticky", ovf_o, 1);
      drain("R6 drop contents");
      pulse_clr(1'b1, 1'b1);
      chk("R9 ovf cleared", ovf_o, 0);
   endtask

   task automatic t_evict();
      full_mode_i = 1'b1;
      fill_up();
      op_push(8'h82);
      chk("R5 ovf on evict", ovf_o, 1);
      chk("R6 evict count", count_o, DEPTH);
      chk("R6 evict head", head_o, 8'hA0);
      drain("R6 evict contents");
      pulse_clr(1'b1, 1'b1);
      full_mode_i = 1'b0;
   endtask

   task automatic t_same_cycle();
      fill_up();
      chk("R8 head before", head_o, 8'h81);
      void'(mq.pop_front());
      mq.push_back(8'h55);
      push_i = 1'b1; push_data_i = 8'h55; pop_i = 1'b1;
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0;
      chk("R8 no ovf", ovf_o, 0);
      chk("R8 count", count_o, DEPTH);
      drain("R8 contents");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_codes();
      t_drop();
      t_evict();
      t_same_cycle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule